// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Processor Core

A compact 8-bit processor that steps through variable-length instructions one byte per clock from a single 32 KB byte address space. Addresses with the top bit clear belong to writable RAM. Addresses with the top bit set belong to a preloaded program store that cannot be written. After reset, execution begins at the first byte of the program store.

The core has four general registers at indices 0 to 3. The status register is at index 4, so every instruction that names a register can also read or write status. The core provides:

- memory load and store;
- byte-wide port input and output through an 8-bit port index;
- ALU operations with zero and carry flags, and single-bit set and clear;
- unconditional jumps, and jumps taken on a register comparison;
- an internal hardware stack;
- halt, which stops the core until reset.

Each instruction takes one cycle for its opcode, one cycle for each operand byte, and one execute cycle. Memory reads are combinational: the system returns the byte at `mem_addr_o` in the same cycle.

Top module: `byte_cpu`

## Requirements
- R1: While reset is low and just after it, the core presents address 0x4000, asserts no memory or port write and keeps `halted_o` low. All registers, including status, read back as zero.
- R2: Opcodes are 0x00 no-op, 0x01 halt, 0x02 load, 0x03 store, 0x04 output, 0x05 input, 0x06 ALU, 0x07 jump, 0x08 conditional jump, 0x09 push and 0x0A pop. Each opcode is followed by its operand bytes. Any other opcode value acts as a one-byte no-op.
- R3: Load (reg, addr-hi, addr-lo) copies the addressed byte into the register. Store (reg, addr-hi, addr-lo) writes the register to that address. Addresses are sent high byte first.
- R4: A store whose address has bit 14 set never raises `mem_we_o`, and the byte at that address stays unchanged.
- R5: Output (reg, port) drives the register value on `port_out_o` and the port number on `port_idx_o` for one cycle with `port_we_o` high. Input (reg, port) loads the byte on `port_in_i` while `port_idx_o` shows the port.
- R6: ALU takes two bytes: a control byte and a second operand byte. In the control byte, bits 3:0 select the operation and bits 6:4 select the destination register. For binary operations the second byte names a source register. The operations are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 not, 6 shift left and 7 shift right. Each writes the result to the destination register. It sets status bit 0 when the result is zero. It sets status bit 1 to the add carry, the subtract borrow, or the bit shifted out; logic operations clear bit 1.
- R7: ALU operation 8 sets a bit and operation 9 clears a bit. The bit number is the second byte. These operations work on any register index 0 to 4, including status, and they leave the flags unchanged.
- R8: Jump (hi, lo) loads the program counter. Conditional jump (cond, hi, lo) compares two registers: bits 1:0 of the cond byte select register A and bits 3:2 select register B. Bits 5:4 select the test: 0 equal, 1 not equal, 2 A below B (unsigned), 3 A not below B. The jump is taken only when the test holds.
- R9: Push (reg) and pop (reg) use a last-in first-out stack of `STACK_DEPTH` bytes.
- R10: A push to a full stack and a pop from an empty stack change neither the stack nor the destination register. Both set status bit 2, which stays set until software writes status.
- R11: Halt raises `halted_o` and keeps it high until reset. No further fetch, write or port access happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 15 | Byte address for fetch, load and store |
| mem_rdata_i | input | 8 | Byte read at `mem_addr_o`, valid in the same cycle |
| mem_wdata_o | output | 8 | Store data |
| mem_we_o | output | 1 | Store strobe, RAM half only |
| port_idx_o | output | 8 | Port number for input and output |
| port_in_i | input | 8 | Input port byte selected by `port_idx_o` |
| port_out_o | output | 8 | Output port data |
| port_we_o | output | 1 | Output strobe |
| halted_o | output | 1 | High once halt has executed |

## Verification
The bench builds the core with `STACK_DEPTH` set to 4, with the address width and register count left at their defaults. The small stack lets a short program fill the stack, push past the limit and then drain it past empty. The bench observes the error bit and the unchanged pop destination through output instructions. The default 15-bit address keeps the RAM and program-store halves at their real boundary, so the blocked store into the upper half is exercised exactly as in the full configuration.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_HLT = 8'h01;
  localparam logic [7:0] OP_LDR = 8'h02;
  localparam logic [7:0] OP_STR = 8'h03;
  localparam logic [7:0] OP_OUT = 8'h04;
  localparam logic [7:0] OP_IN  = 8'h05;
  localparam logic [7:0] OP_ALU = 8'h06;
  localparam logic [7:0] OP_JMP = 8'h07;
  localparam logic [7:0] OP_JPC = 8'h08;
  localparam logic [7:0] OP_PSH = 8'h09;
  localparam logic [7:0] OP_POP = 8'h0A;

  localparam logic [3:0] AL_ADD = 4'd0;
  localparam logic [3:0] AL_SUB = 4'd1;
  localparam logic [3:0] AL_AND = 4'd2;
  localparam logic [3:0] AL_OR  = 4'd3;
  localparam logic [3:0] AL_XOR = 4'd4;
  localparam logic [3:0] AL_NOT = 4'd5;
  localparam logic [3:0] AL_SHL = 4'd6;
  localparam logic [3:0] AL_SHR = 4'd7;
  localparam logic [3:0] AL_SETB = 4'd8;
  localparam logic [3:0] AL_CLRB = 4'd9;

  localparam int ST_Z = 0;
  localparam int ST_C = 1;
  localparam int ST_E = 2;

  typedef enum logic [1:0] {S_FETCH, S_OPND, S_EXEC, S_HALT} state_e;

  function automatic logic [1:0] opnd_len(input logic [7:0] op);
    case (op)
      OP_LDR, OP_STR, OP_JPC:         opnd_len = 2'd3;
      OP_OUT, OP_IN, OP_ALU, OP_JMP:  opnd_len = 2'd2;
      OP_PSH, OP_POP:                 opnd_len = 2'd1;
      OP_NOP, OP_HLT:                 opnd_len = 2'd0;
      default:                        opnd_len = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
  import byte_cpu_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  output logic [7:0] res_o,
  output logic       carry_o,
  output logic       zero_o,
  output logic       flags_we_o,
  output logic       valid_o
);
  logic [8:0] wide;

  always_comb begin
    case (op_i)
      AL_ADD:  wide = {1'b0, a_i} + {1'b0, b_i};
      AL_SUB:  wide = {1'b0, a_i} - {1'b0, b_i};
      AL_AND:  wide = {1'b0, a_i & b_i};
      AL_OR:   wide = {1'b0, a_i | b_i};
      AL_XOR:  wide = {1'b0, a_i ^ b_i};
      AL_NOT:  wide = {1'b0, ~a_i};
      AL_SHL:  wide = {a_i, 1'b0};
      AL_SHR:  wide = {a_i[0], 1'b0, a_i[7:1]};
      AL_SETB: wide = {1'b0, a_i | (8'd1 << b_i[2:0])};
      AL_CLRB: wide = {1'b0, a_i & ~(8'd1 << b_i[2:0])};
      default: wide = {1'b0, a_i};
    endcase
  end

  assign res_o      = wide[7:0];
  assign carry_o    = wide[8];
  assign zero_o     = (wide[7:0] == 8'd0);
  assign flags_we_o = ~op_i[3];
  assign valid_o    = (op_i <= AL_CLRB);
endmodule

// File: rtl/byte_cpu_regs.sv
module byte_cpu_regs
  import byte_cpu_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ra_idx_i,
  output logic [7:0] ra_o,
  input  logic [7:0] rb_idx_i,
  output logic [7:0] rb_o,
  input  logic       we_i,
  input  logic [7:0] w_idx_i,
  input  logic [7:0] w_data_i,
  input  logic       flags_we_i,
  input  logic       zero_i,
  input  logic       carry_i,
  input  logic       err_set_i
);
  localparam logic [7:0] ST_IDX = 8'(NREGS);

  logic [7:0] gpr [NREGS];
  logic [7:0] status, status_nx;

  always_comb begin
    ra_o = '0;
    rb_o = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (ra_idx_i == 8'(i)) ra_o = gpr[i];
      if (rb_idx_i == 8'(i)) rb_o = gpr[i];
    end
    if (ra_idx_i == ST_IDX) ra_o = status;
    if (rb_idx_i == ST_IDX) rb_o = status;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gpr[g] <= '0;
      else if (we_i && w_idx_i == 8'(g)) gpr[g] <= w_data_i;
    end
  end

  always_comb begin
    status_nx = status;
    if (we_i && w_idx_i == ST_IDX) begin
      status_nx = w_data_i;
    end else begin
      if (flags_we_i) begin
        status_nx[ST_Z] = zero_i;
        status_nx[ST_C] = carry_i;
      end
      if (err_set_i) status_nx[ST_E] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status <= '0;
    else         status <= status_nx;
  end

  // R10: error flag raised after a rejected stack access
  a_r10_err_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i && !(we_i && w_idx_i == ST_IDX)) |=> status[ST_E]);

  // R6: flag update lands on the status bits
  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_i && !(we_i && w_idx_i == ST_IDX)) |=> status[ST_Z] == $past(zero_i));
endmodule

// File: rtl/byte_cpu_stack.sv
module byte_cpu_stack #(
  parameter int DEPTH = 255
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic [7:0] din_i,
  output logic [7:0] dout_o,
  output logic       full_o,
  output logic       empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign dout_o  = empty_o ? 8'd0 : mem[cnt - CNT_W'(1)];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[cnt] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt <= '0;
    else if (push_i && !full_o)    cnt <= cnt + CNT_W'(1);
    else if (pop_i && !empty_o)    cnt <= cnt - CNT_W'(1);
  end

  a_r10_push_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> $stable(cnt));
  a_r10_pop_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(cnt));
  a_r9_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> cnt == $past(cnt) + CNT_W'(1));
  a_r10_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import byte_cpu_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int NREGS       = 4,
  parameter int STACK_DEPTH = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic [7:0]        port_idx_o,
  input  logic [7:0]        port_in_i,
  output logic [7:0]        port_out_o,
  output logic              port_we_o,
  output logic              halted_o
);
  localparam logic [ADDR_W-1:0] PC_RESET = {1'b1, {(ADDR_W-1){1'b0}}};

  state_e            state;
  logic [ADDR_W-1:0] pc;
  logic [7:0]        ir;
  logic [7:0]        opnd [3];
  logic [1:0]        need, oidx;

  logic              exec;
  logic [ADDR_W-1:0] data_addr, jmp_addr;
  logic [7:0]        ra_idx, rb_idx, ra_val, rb_val;
  logic [2:0]        dst;
  logic [7:0]        alu_b, alu_res;
  logic              alu_c, alu_z, alu_fwe, alu_valid, alu_ok;
  logic              cond_ok;
  logic              stk_full, stk_empty, stk_push, stk_pop;
  logic [7:0]        stk_dout;
  logic              w_en, f_we, err_set;
  logic [7:0]        w_idx, w_data;

  assign exec      = (state == S_EXEC);
  assign data_addr = ADDR_W'({opnd[1], opnd[2]});
  assign jmp_addr  = ADDR_W'({opnd[0], opnd[1]});
  assign dst       = opnd[0][6:4];

  always_comb begin
    case (ir)
      OP_ALU:  begin ra_idx = {5'b0, dst};            rb_idx = opnd[1]; end
      OP_JPC:  begin ra_idx = {6'b0, opnd[0][1:0]};   rb_idx = {6'b0, opnd[0][3:2]}; end
      default: begin ra_idx = opnd[0];                rb_idx = opnd[1]; end
    endcase
  end

  byte_cpu_regs #(.NREGS(NREGS)) u_regs (
    .clk_i, .rst_ni,
    .ra_idx_i(ra_idx), .ra_o(ra_val), .rb_idx_i(rb_idx), .rb_o(rb_val),
    .we_i(w_en), .w_idx_i(w_idx), .w_data_i(w_data),
    .flags_we_i(f_we), .zero_i(alu_z), .carry_i(alu_c), .err_set_i(err_set)
  );

  assign alu_b = opnd[0][3] ? opnd[1] : rb_val;

  byte_cpu_alu u_alu (
    .op_i(opnd[0][3:0]), .a_i(ra_val), .b_i(alu_b),
    .res_o(alu_res), .carry_o(alu_c), .zero_o(alu_z),
    .flags_we_o(alu_fwe), .valid_o(alu_valid)
  );

  // arithmetic on general registers only; bit ops also reach status
  assign alu_ok = alu_valid && (alu_fwe ? ({5'b0, dst} < 8'(NREGS))
                                        : ({5'b0, dst} <= 8'(NREGS)));

  always_comb begin
    case (opnd[0][5:4])
      2'd0:    cond_ok = (ra_val == rb_val);
      2'd1:    cond_ok = (ra_val != rb_val);
      2'd2:    cond_ok = (ra_val <  rb_val);
      default: cond_ok = (ra_val >= rb_val);
    endcase
  end

  assign stk_push = exec && (ir == OP_PSH);
  assign stk_pop  = exec && (ir == OP_POP);
  assign err_set  = (stk_push && stk_full) || (stk_pop && stk_empty);

  byte_cpu_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i, .rst_ni, .push_i(stk_push), .pop_i(stk_pop), .din_i(ra_val),
    .dout_o(stk_dout), .full_o(stk_full), .empty_o(stk_empty)
  );

  always_comb begin
    w_en   = 1'b0;
    w_idx  = opnd[0];
    w_data = mem_rdata_i;
    f_we   = 1'b0;
    if (exec) begin
      case (ir)
        OP_LDR: w_en = 1'b1;
        OP_IN:  begin w_en = 1'b1; w_data = port_in_i; end
        OP_ALU: begin
          w_en   = alu_ok;
          w_idx  = {5'b0, dst};
          w_data = alu_res;
          f_we   = alu_ok && alu_fwe;
        end
        OP_POP: begin w_en = !stk_empty; w_data = stk_dout; end
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = exec ? data_addr : pc;
  assign mem_wdata_o = ra_val;
  assign mem_we_o    = exec && (ir == OP_STR) && !data_addr[ADDR_W-1];
  assign port_idx_o  = opnd[1];
  assign port_out_o  = ra_val;
  assign port_we_o   = exec && (ir == OP_OUT);
  assign halted_o    = (state == S_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_FETCH;
      pc    <= PC_RESET;
      ir    <= '0;
      need  <= '0;
      oidx  <= '0;
      for (int i = 0; i < 3; i++) opnd[i] <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata_i;
          pc    <= pc + 1'b1;
          need  <= opnd_len(mem_rdata_i);
          oidx  <= '0;
          state <= (opnd_len(mem_rdata_i) == 2'd0) ? S_EXEC : S_OPND;
        end
        S_OPND: begin
          opnd[oidx] <= mem_rdata_i;
          pc         <= pc + 1'b1;
          oidx       <= oidx + 1'b1;
          if (oidx == need - 1'b1) state <= S_EXEC;
        end
        S_EXEC: begin
          state <= (ir == OP_HLT) ? S_HALT : S_FETCH;
          if (ir == OP_JMP)             pc <= jmp_addr;
          if (ir == OP_JPC && cond_ok)  pc <= data_addr;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  a_r4_no_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[ADDR_W-1]);
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  a_r11_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_we_o && !port_we_o));
  a_r2_pc_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_OPND) |=> pc == $past(pc) + 1'b1);
endmodule

// File: tb/byte_cpu_bench.sv
`timescale 1ns/1ps
module byte_cpu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata, port_idx, port_in, port_out;
  logic        mem_we, port_we, halted;

  logic [7:0] rom [512];
  logic [7:0] ram [256];
  logic [7:0] inport [256];
  logic [7:0] lv [16];
  logic [7:0] lp [16];
  int         ln;
  logic       romw;
  int         wp, checks, fails;
  logic       wd_fired;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[14] ? rom[mem_addr[8:0]] : ram[mem_addr[7:0]];
  assign port_in   = inport[port_idx];

  byte_cpu #(.STACK_DEPTH(4)) u_byte_cpu (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .port_idx_o(port_idx), .port_in_i(port_in), .port_out_o(port_out), .port_we_o(port_we),
    .halted_o(halted)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      ln   <= 0;
      romw <= 1'b0;
    end else begin
      if (port_we && ln < 16) begin
        lv[ln] <= port_out;
        lp[ln] <= port_idx;
        ln     <= ln + 1;
      end
      if (mem_we) begin
        if (mem_addr[14]) romw <= 1'b1;
        else              ram[mem_addr[7:0]] <= mem_wdata;
      end
    end
  end

  // op[35:32] a[31:24] b[23:16] result[15:8] status[7:0]
  localparam logic [35:0] ALU_VEC [10] = '{
    {4'd0, 8'h10, 8'h20, 8'h30, 8'h00},
    {4'd0, 8'hF0, 8'h10, 8'h00, 8'h03},
    {4'd1, 8'h05, 8'h07, 8'hFE, 8'h02},
    {4'd1, 8'h07, 8'h07, 8'h00, 8'h01},
    {4'd2, 8'hF0, 8'h0F, 8'h00, 8'h01},
    {4'd3, 8'hF0, 8'h0F, 8'hFF, 8'h00},
    {4'd4, 8'hAA, 8'hFF, 8'h55, 8'h00},
    {4'd5, 8'h0F, 8'h00, 8'hF0, 8'h00},
    {4'd6, 8'h81, 8'h00, 8'h02, 8'h02},
    {4'd7, 8'h01, 8'h00, 8'h00, 8'h03}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prog_start();
    wp = 0;
    for (int i = 0; i < 512; i++) rom[i] = 8'h00;
  endtask

  task automatic emit(input logic [7:0] b);
    rom[wp] = b;
    wp++;
  endtask

  task automatic e3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    emit(a); emit(b); emit(c);
  endtask

  task automatic jpc_skip3(input logic [7:0] cnd);
    logic [15:0] t;
    t = 16'h4000 + 16'(wp) + 16'd7;
    emit(8'h08); emit(cnd); emit(t[15:8]); emit(t[7:0]);
  endtask

  task automatic jmp_skip3();
    logic [15:0] t;
    t = 16'h4000 + 16'(wp) + 16'd6;
    e3(8'h07, t[15:8], t[7:0]);
  endtask

  task automatic run(input string tag);
    int cyc;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " halted"}, int'(halted), 1);
  endtask

  task automatic body();
    logic [35:0] v;
    for (int i = 0; i < 256; i++) begin inport[i] = 8'h00; ram[i] = 8'h00; end

    // R1: reset state at the ports
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset addr", int'(mem_addr), 'h4000);
    chk("R1 reset halted", int'(halted), 0);
    chk("R1 reset mem_we", int'(mem_we), 0);
    chk("R1 reset port_we", int'(port_we), 0);
    prog_start();
    e3(8'h04, 8'h04, 8'h00); e3(8'h04, 8'h00, 8'h00); emit(8'h01);
    run("R1");
    chk("R1 status zero", int'(lv[0]), 0);
    chk("R1 r0 zero", int'(lv[1]), 0);

    // R6: ALU table
    for (int k = 0; k < 10; k++) begin
      v = ALU_VEC[k];
      inport[1] = v[31:24];
      inport[2] = v[23:16];
      prog_start();
      e3(8'h05, 8'h00, 8'h01);
      e3(8'h05, 8'h01, 8'h02);
      e3(8'h06, {4'h0, v[35:32]}, 8'h01);
      e3(8'h04, 8'h00, 8'h00);
      e3(8'h04, 8'h04, 8'h00);
      emit(8'h01);
      run("R6");
      chk("R6 result", int'(lv[0]), int'(v[15:8]));
      chk("R6 flags", int'(lv[1]), int'(v[7:0]));
    end

    // R7: bit set/clear incl. status register
    prog_start();
    e3(8'h06, 8'h48, 8'h01); e3(8'h04, 8'h04, 8'h00);
    e3(8'h06, 8'h28, 8'h07); e3(8'h04, 8'h02, 8'h00);
    e3(8'h06, 8'h49, 8'h01); e3(8'h04, 8'h04, 8'h00);
    emit(8'h01);
    run("R7");
    chk("R7 set status bit1", int'(lv[0]), 'h02);
    chk("R7 set r2 bit7", int'(lv[1]), 'h80);
    chk("R7 clear status bit1", int'(lv[2]), 'h00);

    // R3, R5: store/load with big-endian address, port index
    inport[1] = 8'h5A;
    inport[200] = 8'h3C;
    rom[9'h100] = 8'h77;
    prog_start();
    rom[9'h100] = 8'h77;
    e3(8'h05, 8'h00, 8'h01);
    emit(8'h03); e3(8'h00, 8'h00, 8'h12);
    emit(8'h02); e3(8'h03, 8'h00, 8'h12);
    e3(8'h04, 8'h03, 8'h05);
    emit(8'h02); e3(8'h02, 8'h41, 8'h00);
    e3(8'h04, 8'h02, 8'h06);
    e3(8'h05, 8'h01, 8'hC8);
    e3(8'h04, 8'h01, 8'hFE);
    emit(8'h01);
    run("R3");
    chk("R3 ram byte stored", int'(ram[8'h12]), 'h5A);
    chk("R3 load from ram", int'(lv[0]), 'h5A);
    chk("R5 out port idx", int'(lp[0]), 'h05);
    chk("R3 load from program store", int'(lv[1]), 'h77);
    chk("R5 in port 200", int'(lv[2]), 'h3C);
    chk("R5 out port 254 idx", int'(lp[2]), 'hFE);

    // R4: store into upper half is dropped
    inport[1] = 8'h11;
    prog_start();
    rom[9'h080] = 8'h99;
    e3(8'h05, 8'h00, 8'h01);
    emit(8'h03); e3(8'h00, 8'h40, 8'h80);
    emit(8'h02); e3(8'h01, 8'h40, 8'h80);
    e3(8'h04, 8'h01, 8'h00);
    emit(8'h01);
    run("R4");
    chk("R4 no write strobe to upper half", int'(romw), 0);
    chk("R4 byte unchanged", int'(lv[0]), 'h99);

    // R8: jumps
    inport[1] = 8'h05;
    inport[2] = 8'h09;
    prog_start();
    e3(8'h05, 8'h00, 8'h01);
    e3(8'h05, 8'h01, 8'h02);
    jpc_skip3(8'h24); e3(8'h04, 8'h00, 8'h10);
    jpc_skip3(8'h04); e3(8'h04, 8'h00, 8'h11);
    jpc_skip3(8'h14); e3(8'h04, 8'h00, 8'h12);
    jpc_skip3(8'h34); e3(8'h04, 8'h01, 8'h13);
    jmp_skip3();      e3(8'h04, 8'h00, 8'h14);
    e3(8'h04, 8'h01, 8'h15);
    emit(8'h01);
    run("R8");
    chk("R8 output count", ln, 3);
    chk("R8 eq not taken", int'(lp[0]), 'h11);
    chk("R8 ge not taken", int'(lp[1]), 'h13);
    chk("R8 jmp lands", int'(lp[2]), 'h15);

    // R9: LIFO order
    prog_start();
    e3(8'h05, 8'h00, 8'h01);
    e3(8'h05, 8'h01, 8'h02);
    emit(8'h09); emit(8'h00);
    emit(8'h09); emit(8'h01);
    emit(8'h0A); emit(8'h02);
    emit(8'h0A); emit(8'h03);
    e3(8'h04, 8'h02, 8'h00);
    e3(8'h04, 8'h03, 8'h00);
    e3(8'h04, 8'h04, 8'h00);
    emit(8'h01);
    run("R9");
    chk("R9 first pop", int'(lv[0]), 'h09);
    chk("R9 second pop", int'(lv[1]), 'h05);
    chk("R9 no error", int'(lv[2]), 'h00);

    // R10: overflow and underflow with depth 4
    prog_start();
    e3(8'h05, 8'h00, 8'h01);
    for (int i = 0; i < 5; i++) begin emit(8'h09); emit(8'h00); end
    e3(8'h04, 8'h04, 8'h00);
    e3(8'h06, 8'h49, 8'h02);
    e3(8'h04, 8'h04, 8'h00);
    e3(8'h05, 8'h03, 8'h02);
    for (int i = 0; i < 4; i++) begin emit(8'h0A); emit(8'h02); end
    emit(8'h0A); emit(8'h03);
    e3(8'h04, 8'h02, 8'h00);
    e3(8'h04, 8'h03, 8'h00);
    e3(8'h04, 8'h04, 8'h00);
    emit(8'h01);
    run("R10");
    chk("R10 full push sets error", int'(lv[0]), 'h04);
    chk("R10 error cleared by write", int'(lv[1]), 'h00);
    chk("R10 last valid pop", int'(lv[2]), 'h05);
    chk("R10 empty pop leaves reg", int'(lv[3]), 'h09);
    chk("R10 empty pop sets error", int'(lv[4]), 'h04);

    // R2: unknown opcodes are one-byte no-ops
    prog_start();
    emit(8'hFF); emit(8'hC3); emit(8'h00);
    e3(8'h05, 8'h00, 8'h01);
    e3(8'h04, 8'h00, 8'h07);
    emit(8'h01);
    run("R2");
    chk("R2 output count", ln, 1);
    chk("R2 value after unknown", int'(lv[0]), 'h05);
    chk("R2 port after unknown", int'(lp[0]), 'h07);

    // R11: halt holds and nothing follows
    prog_start();
    e3(8'h04, 8'h00, 8'h00);
    emit(8'h01);
    e3(8'h04, 8'h00, 8'h01);
    run("R11");
    repeat (20) @(negedge clk);
    chk("R11 still halted", int'(halted), 1);
    chk("R11 no output after halt", ln, 1);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    wd_fired = 1'b0;
    fork
      body();
      begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule